// File: doc/BRIEF.md
# Boot ROM Overlay Controller

This block sits on a 32-bit processor bus in front of a 1 MB RAM. After reset, a 128-byte bootstrap ROM covers the lowest bus addresses, so the processor fetches its first instructions from the ROM rather than from uninitialised RAM. Writes into that window always land in RAM. Boot code can therefore copy itself or a loader into RAM underneath the ROM while still running from it.

The boot code removes the overlay by reading a dedicated disable location. That read returns zero and starts a short countdown. The overlay stays in place until the countdown expires, so instructions already in flight still come from ROM. After that, the lowest addresses show RAM until the next reset. The block also decodes a one-bit communication port at a heavily mirrored address. A write stores a bit that drives an output pin. A read returns the sampled state of an input pin.

Read data comes back one cycle after the request and is flagged by a valid strobe. The RAM port is expected to return read data one cycle after its enable.

Top module: `boot_overlay_ctrl`

## Requirements
- R1: While reset is active, and after it is released, the overlay is enabled, the countdown is idle, `link_out` is 0 and `bus_rvalid` is 0. `rst_n` is asynchronous and is released through a two-stage synchroniser.
- R2: While the overlay is enabled, a read of byte address 0x00..0x7F returns the ROM word at index `addr[6:2]` in the following cycle, and no RAM access is made. ROM byte lane k (bits 8k+7..8k) of word i holds `(4*i + k) XOR 0xA5`.
- R3: While the overlay is disabled, a read of the window returns the RAM word at the same address.
- R4: A write anywhere below 0x00100000, including the window, raises `ram_en` and `ram_we` in the same cycle, with `ram_addr = addr[19:2]`. This holds whether or not the overlay is enabled.
- R5: A read of 0x01800000..0x01800003 returns 0. If the overlay is enabled and no countdown is pending, the read starts a countdown of 5 cycles. Reads issued 1 to 5 cycles after the disable read still see ROM, and reads issued 6 or more cycles after it see RAM.
- R6: A disable read made while a countdown is pending does not restart the countdown. A disable read made while the overlay is already off has no effect apart from returning 0.
- R7: The link port is hit by any address with `addr[31:22] = 0x001` and `addr[1:0] = 0`. A write stores `wdata[0]` on `link_out`. A read returns, in bit 0, the value of `link_in` registered in the cycle before the read, with the upper bits zero.
- R8: Any other address returns 0 on a read. A write to such an address causes no RAM access and leaves `link_out` unchanged, for example at 0x00400001 or 0x00100000.
- R9: A read of RAM above the window, from 0x80 to 0xFFFFF, always returns RAM data.
- R10: Once the overlay is cleared, only a reset enables it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read request, one cycle per access |
| bus_wr | input | 1 | Write request, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 18 | RAM word address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after ram_en |
| link_in | input | 1 | Incoming communication bit |
| link_out | output | 1 | Outgoing communication bit |

## Verification
The assertions take for granted that `bus_rd` and `bus_wr` are never high in the same cycle. They also take for granted that the bus address is stable for the cycle of each request. Under those conditions the countdown check, which requires the counter to fall by one on every cycle while it is pending, holds even when disable reads are repeated. The stimulus drives every access from a single task per cycle with exactly one strobe raised. It holds `link_in` stable for several cycles before reading the link port.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2,
    SRC_LINK = 2'd3
  } rd_src_e;

  typedef struct packed {
    logic win;
    logic ram;
    logic link;
    logic dis;
  } hit_t;

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rst_s_n = pipe_q[STAGES-1];

endmodule

// File: rtl/boot_addr_decode.sv
module boot_addr_decode
  import boot_ovl_pkg::*;
#(
  parameter int          AW          = 32,
  parameter int          RAM_LOG2    = 20,
  parameter int          WIN_LOG2    = 7,
  parameter logic [31:0] LINK_BASE   = 32'h0040_0000,
  parameter logic [31:0] LINK_MIRROR = 32'h003F_FFFC,
  parameter logic [31:0] DIS_BASE    = 32'h0180_0000
) (
  input  logic [AW-1:0] addr,
  output hit_t          hit
);

  localparam logic [AW-1:0] LinkKeep = ~LINK_MIRROR[AW-1:0];

  always_comb begin
    hit.ram  = (addr[AW-1:RAM_LOG2] == '0);
    hit.win  = (addr[AW-1:WIN_LOG2] == '0);
    hit.link = ((addr & LinkKeep) == LINK_BASE[AW-1:0]);
    hit.dis  = (addr[AW-1:2] == DIS_BASE[AW-1:2]);
  end

endmodule

// File: rtl/boot_rom_lanes.sv
module boot_rom_lanes #(
  parameter int         WORDS = 32,
  parameter logic [7:0] SEED  = 8'hA5,
  localparam int        IW    = $clog2(WORDS)
) (
  input  logic [IW-1:0] idx,
  output logic [31:0]   word
);

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [7:0] tbl [WORDS];

    always_comb begin
      for (int i = 0; i < WORDS; i++) begin
        tbl[i] = 8'((i * 4 + k) % 256) ^ SEED;
      end
    end

    assign word[8*k +: 8] = tbl[idx];
  end

endmodule

// File: rtl/boot_overlay_fsm.sv
module boot_overlay_fsm #(
  parameter int  DELAY = 5,
  localparam int CW    = $clog2(DELAY + 1)
) (
  input  logic          clk,
  input  logic          rst_s_n,
  input  logic          dis_trig,
  output logic          ovl_on,
  output logic [CW-1:0] cnt
);

  logic          ovl_q;
  logic          ovl_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    ovl_d = ovl_q;
    cnt_d = cnt_q;
    if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        ovl_d = 1'b0;
      end
    end else if (dis_trig && ovl_q) begin
      cnt_d = CW'(DELAY);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ovl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      ovl_q <= ovl_d;
      cnt_q <= cnt_d;
    end
  end

  assign ovl_on = ovl_q;
  assign cnt    = cnt_q;

endmodule

// File: rtl/boot_overlay_ctrl.sv
module boot_overlay_ctrl
  import boot_ovl_pkg::*;
#(
  parameter int          RAM_BYTES   = 1048576,
  parameter int          ROM_WORDS   = 32,
  parameter int          DIS_DELAY   = 5,
  parameter logic [7:0]  ROM_SEED    = 8'hA5,
  parameter logic [31:0] LINK_BASE   = 32'h0040_0000,
  parameter logic [31:0] LINK_MIRROR = 32'h003F_FFFC,
  parameter logic [31:0] DIS_BASE    = 32'h0180_0000,
  localparam int         RAM_LOG2    = $clog2(RAM_BYTES),
  localparam int         RAM_AW      = RAM_LOG2 - 2,
  localparam int         ROM_IW      = $clog2(ROM_WORDS),
  localparam int         WIN_LOG2    = ROM_IW + 2,
  localparam int         CNT_W       = $clog2(DIS_DELAY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [31:0]       ram_wdata,
  input  logic [31:0]       ram_rdata,
  input  logic              link_in,
  output logic              link_out
);

  logic             rst_s_n;
  hit_t             hit;
  logic [31:0]      rom_word;
  logic             ovl_on;
  logic [CNT_W-1:0] dis_cnt;
  logic             dis_trig;
  logic             rom_sel;

  rd_src_e          src_d;
  rd_src_e          src_q;
  logic [31:0]      held_d;
  logic [31:0]      held_q;
  logic             rvalid_d;
  logic             rvalid_q;
  logic             in_d;
  logic             in_q;
  logic             out_d;
  logic             out_q;
  logic             out_en;

  boot_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  boot_addr_decode #(
    .AW          (32),
    .RAM_LOG2    (RAM_LOG2),
    .WIN_LOG2    (WIN_LOG2),
    .LINK_BASE   (LINK_BASE),
    .LINK_MIRROR (LINK_MIRROR),
    .DIS_BASE    (DIS_BASE)
  ) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  boot_rom_lanes #(
    .WORDS (ROM_WORDS),
    .SEED  (ROM_SEED)
  ) u_rom (
    .idx  (bus_addr[WIN_LOG2-1:2]),
    .word (rom_word)
  );

  assign dis_trig = bus_rd && hit.dis;

  boot_overlay_fsm #(.DELAY(DIS_DELAY)) u_fsm (
    .clk      (clk),
    .rst_s_n  (rst_s_n),
    .dis_trig (dis_trig),
    .ovl_on   (ovl_on),
    .cnt      (dis_cnt)
  );

  // Read steering: ROM shadows RAM only inside the window while enabled.
  assign rom_sel = hit.win && ovl_on;

  always_comb begin
    src_d = SRC_ZERO;
    if (bus_rd) begin
      if (rom_sel) begin
        src_d = SRC_ROM;
      end else if (hit.ram) begin
        src_d = SRC_RAM;
      end else if (hit.link) begin
        src_d = SRC_LINK;
      end
    end
  end

  always_comb begin
    unique case (src_d)
      SRC_ROM:  held_d = rom_word;
      SRC_LINK: held_d = {31'd0, in_q};
      default:  held_d = '0;
    endcase
  end

  assign rvalid_d = bus_rd;
  assign in_d     = link_in;
  assign out_en   = bus_wr && hit.link;
  assign out_d    = out_en ? bus_wdata[0] : out_q;

  // RAM port: writes always pass, reads only when not shadowed.
  assign ram_we    = bus_wr && hit.ram;
  assign ram_en    = ram_we || (bus_rd && hit.ram && !rom_sel);
  assign ram_addr  = bus_addr[RAM_LOG2-1:2];
  assign ram_wdata = bus_wdata;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      src_q    <= SRC_ZERO;
      held_q   <= '0;
      rvalid_q <= 1'b0;
      in_q     <= 1'b0;
      out_q    <= 1'b0;
    end else begin
      src_q    <= src_d;
      held_q   <= held_d;
      rvalid_q <= rvalid_d;
      in_q     <= in_d;
      out_q    <= out_d;
    end
  end

  assign bus_rdata  = (src_q == SRC_RAM) ? ram_rdata : held_q;
  assign bus_rvalid = rvalid_q;
  assign link_out   = out_q;

endmodule

// File: rtl/boot_overlay_ctrl_chk.sv
module boot_overlay_ctrl_chk #(
  parameter int          CNT_W     = 3,
  parameter int          DELAY     = 5,
  parameter int          RAM_LOG2  = 20,
  parameter logic [31:0] DIS_BASE  = 32'h0180_0000,
  parameter logic [31:0] LINK_BASE = 32'h0040_0000
) (
  input logic                clk,
  input logic                rst_s_n,
  input logic [31:0]         bus_addr,
  input logic                bus_rd,
  input logic                bus_wr,
  input logic [31:0]         bus_wdata,
  input logic [31:0]         bus_rdata,
  input logic                bus_rvalid,
  input logic                ram_en,
  input logic                ram_we,
  input logic [RAM_LOG2-3:0] ram_addr,
  input logic                link_out,
  input logic                ovl_on,
  input logic [CNT_W-1:0]    dis_cnt
);

  logic is_dis;
  logic is_ram;
  logic is_link;

  assign is_dis  = (bus_addr[31:2] == DIS_BASE[31:2]);
  assign is_ram  = (bus_addr[31:RAM_LOG2] == '0);
  assign is_link = (bus_addr[31:22] == LINK_BASE[31:22]) && (bus_addr[1:0] == 2'b00);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rst_s_n) |-> (!link_out && !bus_rvalid && ovl_on && dis_cnt == '0));

  assert_ram_write_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_wr && is_ram) |-> (ram_en && ram_we && ram_addr == bus_addr[RAM_LOG2-1:2]));

  assert_disable_zero_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rd && is_dis) |=> (bus_rvalid && bus_rdata == 32'd0));

  assert_countdown_load_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rd && is_dis && ovl_on && dis_cnt == '0) |=> (dis_cnt == CNT_W'(DELAY)));

  assert_clear_at_expiry_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(ovl_on) |-> ($past(dis_cnt) == CNT_W'(1)));

  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dis_cnt != '0) |=> (dis_cnt == CNT_W'($past(dis_cnt) - 1'b1)));

  assert_link_store_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_wr && is_link) |=> (link_out == $past(bus_wdata[0])));

  assert_no_ram_outside_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((bus_rd || bus_wr) && !is_ram) |-> !ram_en);

  assert_no_reenable_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$rose(ovl_on));

endmodule

bind boot_overlay_ctrl boot_overlay_ctrl_chk #(
  .CNT_W     (CNT_W),
  .DELAY     (DIS_DELAY),
  .RAM_LOG2  (RAM_LOG2),
  .DIS_BASE  (DIS_BASE),
  .LINK_BASE (LINK_BASE)
) u_chk (
  .clk        (clk),
  .rst_s_n    (rst_s_n),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .ram_en     (ram_en),
  .ram_we     (ram_we),
  .ram_addr   (ram_addr),
  .link_out   (link_out),
  .ovl_on     (ovl_on),
  .dis_cnt    (dis_cnt)
);

// File: tb/boot_overlay_ctrl_bench.sv
module boot_overlay_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic [31:0] bus_addr;
  logic        bus_rd;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        ram_en;
  logic        ram_we;
  logic [17:0] ram_addr;
  logic [31:0] ram_wdata;
  logic [31:0] ram_rdata;
  logic        link_in;
  logic        link_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] mem [256];

  boot_overlay_ctrl u_boot_overlay_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .ram_rdata  (ram_rdata),
    .link_in    (link_in),
    .link_out   (link_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Small RAM model: one-cycle read latency, low address bits only.
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
      else        ram_rdata <= mem[ram_addr[7:0]];
    end
  end

  function automatic logic [31:0] rom_exp(input int i);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = 8'((4 * i + k) % 256) ^ 8'hA5;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d,
                          output logic en_seen, output logic we_seen);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    #1;
    en_seen = ram_en;
    we_seen = ram_we;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [31:0] a, output logic [31:0] d, output logic en_seen);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    #1;
    en_seen = ram_en;
    @(negedge clk);
    d = bus_rdata;
    chk("R2/R3 rvalid", {31'd0, bus_rvalid}, 32'd1);
    bus_rd = 1'b0;
  endtask

  // Disable read in cycle 0, optional repeat in cycle 3, reads of word 4 elsewhere.
  task automatic run_countdown(input bit second_dis);
    logic [31:0] got [8];
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k > 0) got[k-1] = bus_rdata;
      bus_rd = 1'b1; bus_wr = 1'b0;
      if (k == 0) bus_addr = 32'h0180_0000;
      else if (second_dis && k == 3) bus_addr = 32'h0180_0003;
      else bus_addr = 32'h0000_0010;
    end
    @(negedge clk);
    got[7] = bus_rdata;
    bus_rd = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (k == 0) chk("R5 disable read zero", got[k], 32'd0);
      else if (second_dis && k == 3) chk("R6 repeat disable zero", got[k], 32'd0);
      else if (k <= 5) chk(second_dis ? "R6 still ROM" : "R5 still ROM", got[k], rom_exp(4));
      else chk(second_dis ? "R6 RAM after expiry" : "R5 RAM after expiry", got[k], 32'hC0DE_0004);
    end
  endtask

  task automatic t_reset_R1();
    do_reset();
    chk("R1 link_out", {31'd0, link_out}, 32'd0);
    chk("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
  endtask

  task automatic t_fill_R4();
    logic en, we;
    for (int i = 0; i < 32; i++) begin
      do_write(32'(i * 4), 32'hC0DE_0000 + 32'(i), en, we);
      if (i == 0 || i == 31) chk("R4 window write strobes", {30'd0, en, we}, 32'd3);
    end
    do_write(32'h0000_0200, 32'h5151_A0A0, en, we);
    chk("R4 ram write strobes", {30'd0, en, we}, 32'd3);
  endtask

  task automatic t_rom_R2_R9();
    logic [31:0] d; logic en;
    do_read(32'h0000_0000, d, en); chk("R2 word0", d, rom_exp(0));
    chk("R2 no RAM access", {31'd0, en}, 32'd0);
    do_read(32'h0000_0010, d, en); chk("R2 word4", d, rom_exp(4));
    do_read(32'h0000_007C, d, en); chk("R2 word31", d, rom_exp(31));
    do_read(32'h0000_0200, d, en); chk("R9 RAM above window", d, 32'h5151_A0A0);
  endtask

  task automatic t_outside_R8();
    logic [31:0] d; logic en, we;
    do_read(32'h0010_0000, d, en);
    chk("R8 unmapped read zero", d, 32'd0);
    chk("R8 unmapped read no RAM", {31'd0, en}, 32'd0);
    do_write(32'h0010_0000, 32'hFFFF_FFFF, en, we);
    chk("R8 unmapped write no RAM", {30'd0, en, we}, 32'd0);
  endtask

  task automatic t_link_R7_R8();
    logic [31:0] d; logic en, we;
    link_in = 1'b1;
    repeat (3) @(negedge clk);
    do_read(32'h007F_FFFC, d, en); chk("R7 link read high", d, 32'd1);
    link_in = 1'b0;
    repeat (3) @(negedge clk);
    do_read(32'h0040_0000, d, en); chk("R7 link read low", d, 32'd0);
    do_write(32'h0040_0010, 32'h0000_0001, en, we);
    chk("R7 link_out set", {31'd0, link_out}, 32'd1);
    do_write(32'h0041_2344, 32'h0000_0002, en, we);
    chk("R7 link_out cleared by bit0", {31'd0, link_out}, 32'd0);
    do_write(32'h0040_0001, 32'h0000_0001, en, we);
    chk("R8 misaligned not link", {31'd0, link_out}, 32'd0);
    do_write(32'h0080_0000, 32'h0000_0001, en, we);
    chk("R8 bit23 not link", {31'd0, link_out}, 32'd0);
  endtask

  task automatic t_disable_R5_R3_R6();
    logic [31:0] d; logic en;
    run_countdown(1'b0);
    do_read(32'h0000_007C, d, en); chk("R3 RAM word31", d, 32'hC0DE_001F);
    do_read(32'h0180_0000, d, en); chk("R6 disable when off zero", d, 32'd0);
    repeat (8) @(negedge clk);
    do_read(32'h0000_0000, d, en); chk("R6 stays RAM", d, 32'hC0DE_0000);
  endtask

  task automatic t_rearm_R10_R6();
    logic [31:0] d; logic en;
    do_reset();
    do_read(32'h0000_0000, d, en); chk("R10 reset re-arms ROM", d, rom_exp(0));
    run_countdown(1'b1);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_wdata = '0; link_in = 1'b0; ram_rdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    t_reset_R1();
    t_fill_R4();
    t_rom_R2_R9();
    t_outside_R8();
    t_link_R7_R8();
    t_disable_R5_R3_R6();
    t_rearm_R10_R6();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule